// File: doc/BRIEF.md
# 12-Hour BCD Time-of-Day Counter

This block keeps the time of day as six BCD digits (hours, minutes and seconds) on a 12-hour face. A small divider turns a faster reference enable into a one-clock pulse per second. That pulse drives a synchronous chain of counters. The seconds and minutes stages are each a units digit that counts 0 to 9, feeding a tens digit that counts 0 to 5. The hours stage counts 1 through 12 and then starts again at 1.

All registers run on the same clock, and no counter output ever acts as a clock. Each digit has a count-enable input. Its carry output is the AND of that enable with the digit's terminal value, and the carry is the enable for the next digit. A carry therefore passes through the whole chain in the same cycle as the second pulse. The outputs go straight to a display driver, which is outside this block.

Top module: `bcd_clock12`

## Requirements
- R1: While the synchronous reset is high, the face is set at the next clock edge to 12:00:00 (hour tens 1, hour units 2, all other digits 0), and the prescaler count is cleared.
- R2: `tick_1hz` is high for exactly one cycle for every PRESCALE_DIV cycles on which `ref_tick` is high. It is high in the same cycle as the PRESCALE_DIV-th such `ref_tick`. Cycles on which `ref_tick` is low are not counted.
- R3: Seconds and minutes are shown as two BCD digits each: units 0..9 and tens 0..5. Each second pulse adds one to the seconds, and 59 is followed by 00.
- R4: The minutes advance at the same clock edge on which the seconds go from 59 to 00, and only then. The hours advance in the same way when the minutes and seconds go from 59:59 to 00:00.
- R5: One second pulse at 11:59:59 gives 12:00:00.
- R6: One second pulse at 12:59:59 gives 01:00:00. The hours never show 00 or any value above 12, and the hour tens digit is only ever 0 or 1.
- R7: One second pulse at 09:59:59 gives 10:00:00: the hour units carry into the hour tens.
- R8: On a cycle without a second pulse, none of the six digits changes.
- R9: Reset taken in the middle of a count returns the face to 12:00:00 and restarts the prescaler count, whatever the earlier state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for every register |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | Reference-rate enable, counted by the prescaler |
| tick_1hz | output | 1 | One-cycle pulse per second, the enable of the time chain |
| sec_ones | output | 4 | Seconds units digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD |
| min_ones | output | 4 | Minutes units digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD |
| hr_ones | output | 4 | Hours units digit, BCD |
| hr_tens | output | 4 | Hours tens digit, BCD (0 or 1) |

## Verification
The bench builds the block with PRESCALE_DIV set to 2 instead of the default 60. A full twelve-hour cycle then takes about 86,400 clocks, which is enough to pass through the 09:59:59, 11:59:59 and 12:59:59 turnovers and still test the prescaler counter. First, a random stretch of `ref_tick` with gaps is checked every cycle against a reference of seconds-of-day and reference-count. Then `ref_tick` is held high for a whole face cycle. A reset taken in the middle of a count closes the run.

// File: rtl/clk12_pkg.sv
package clk12_pkg;
   localparam int BCD_W = 4;
   typedef logic [BCD_W-1:0] bcd_t;

   // next value of a digit that wraps at modulus m
   function automatic bcd_t bcd_next(input bcd_t v, input int m);
      if (int'(v) >= m - 1) return '0;
      return v + bcd_t'(1);
   endfunction
endpackage

// File: rtl/clk12_prescaler.sv
module clk12_prescaler #(
   parameter int DIV = 60
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_tick,
   output logic pulse
);
   initial begin
      assert (DIV >= 1) else $error("clk12_prescaler: DIV must be at least 1");
   end

   generate
      if (DIV == 1) begin : g_bypass
         assign pulse = ref_tick;
      end else begin : g_divide
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt;
         logic          at_last;

         assign at_last = (cnt == LAST);
         assign pulse   = ref_tick && at_last;

         always_ff @(posedge clk) begin
            if (rst)           cnt <= '0;
            else if (ref_tick) cnt <= at_last ? '0 : cnt + CW'(1);
         end

         // R2: the second pulse never lasts two cycles
         a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
            pulse |=> !pulse);
         // R2: the count stays inside its range
         a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
            cnt <= LAST);
         // R2: a low reference cycle leaves the count alone
         a_r2_gap_hold: assert property (@(posedge clk) disable iff (rst)
            !ref_tick |=> $stable(cnt));
      end
   endgenerate
endmodule

// File: rtl/clk12_bcd_digit.sv
module clk12_bcd_digit
   import clk12_pkg::*;
#(
   parameter int MODULUS   = 10,
   parameter int RESET_VAL = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic ent,
   input  logic load,
   input  bcd_t load_val,
   output bcd_t q,
   output logic rco
);
   initial begin
      assert (MODULUS >= 2 && MODULUS <= 10)
         else $error("clk12_bcd_digit: MODULUS out of BCD range");
      assert (RESET_VAL >= 0 && RESET_VAL < MODULUS)
         else $error("clk12_bcd_digit: RESET_VAL out of range");
   end

   localparam bcd_t TERMINAL = bcd_t'(MODULUS - 1);

   always_ff @(posedge clk) begin
      if (rst)       q <= bcd_t'(RESET_VAL);
      else if (load) q <= load_val;
      else if (ent)  q <= bcd_next(q, MODULUS);
   end

   assign rco = ent && (q == TERMINAL);

   // R3: the digit never leaves its BCD range
   a_r3_digit_range: assert property (@(posedge clk) disable iff (rst)
      q <= TERMINAL);
   // R8: with no enable and no load the digit holds
   a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      (!ent && !load) |=> $stable(q));
endmodule

// File: rtl/clk12_sexa_stage.sv
module clk12_sexa_stage
   import clk12_pkg::*;
#(
   parameter int UNITS_MOD = 10,
   parameter int TENS_MOD  = 6
) (
   input  logic clk,
   input  logic rst,
   input  logic ent,
   output bcd_t ones,
   output bcd_t tens,
   output logic rco
);
   logic ones_rco;

   clk12_bcd_digit #(.MODULUS(UNITS_MOD), .RESET_VAL(0)) u_ones (
      .clk(clk), .rst(rst), .ent(ent), .load(1'b0), .load_val('0),
      .q(ones), .rco(ones_rco));

   clk12_bcd_digit #(.MODULUS(TENS_MOD), .RESET_VAL(0)) u_tens (
      .clk(clk), .rst(rst), .ent(ones_rco), .load(1'b0), .load_val('0),
      .q(tens), .rco(rco));

   // R4: a stage carry leaves both digits at zero
   a_r4_stage_wrap: assert property (@(posedge clk) disable iff (rst)
      rco |=> (ones == '0 && tens == '0));
   // R3: the tens digit moves only when the units wrap
   a_r3_tens_step: assert property (@(posedge clk) disable iff (rst)
      !$stable(tens) |-> ($past(ones) == bcd_t'(UNITS_MOD - 1) && ones == '0));
endmodule

// File: rtl/clk12_hour_stage.sv
module clk12_hour_stage
   import clk12_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic ent,
   output bcd_t ones,
   output bcd_t tens
);
   logic top_hour;   // tens digit is 1
   logic wrap;       // 12 -> 01 on this tick
   logic ones_rco;

   assign top_hour = (tens == bcd_t'(1));
   assign wrap     = ent && top_hour && (ones == bcd_t'(2));

   clk12_bcd_digit #(.MODULUS(10), .RESET_VAL(2)) u_ones (
      .clk(clk), .rst(rst), .ent(ent), .load(wrap), .load_val(bcd_t'(1)),
      .q(ones), .rco(ones_rco));

   always_ff @(posedge clk) begin
      if (rst)           tens <= bcd_t'(1);
      else if (wrap)     tens <= '0;
      else if (ones_rco) tens <= bcd_t'(1);
   end

   // R6: the hour shown is always 1..12
   a_r6_hour_range: assert property (@(posedge clk) disable iff (rst)
      (tens <= bcd_t'(1)) && !(tens == '0 && ones == '0)
      && !(tens == bcd_t'(1) && ones > bcd_t'(2)));
   // R6: 12 turns into 01
   a_r6_wrap_to_one: assert property (@(posedge clk) disable iff (rst)
      (ent && tens == bcd_t'(1) && ones == bcd_t'(2)) |=>
      (tens == '0 && ones == bcd_t'(1)));
   // R5: 11 turns into 12
   a_r5_eleven_to_twelve: assert property (@(posedge clk) disable iff (rst)
      (ent && tens == bcd_t'(1) && ones == bcd_t'(1)) |=>
      (tens == bcd_t'(1) && ones == bcd_t'(2)));
   // R7: 09 turns into 10
   a_r7_nine_to_ten: assert property (@(posedge clk) disable iff (rst)
      (ent && tens == '0 && ones == bcd_t'(9)) |=>
      (tens == bcd_t'(1) && ones == '0));
endmodule

// File: rtl/bcd_clock12.sv
module bcd_clock12
   import clk12_pkg::*;
#(
   parameter int PRESCALE_DIV = 60
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       ref_tick,
   output logic       tick_1hz,
   output logic [3:0] sec_ones,
   output logic [3:0] sec_tens,
   output logic [3:0] min_ones,
   output logic [3:0] min_tens,
   output logic [3:0] hr_ones,
   output logic [3:0] hr_tens
);
   initial begin
      assert (BCD_W == 4) else $error("bcd_clock12: digit ports are 4 bits wide");
   end

   logic sec_rco;
   logic min_rco;

   clk12_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
      .clk(clk), .rst(rst), .ref_tick(ref_tick), .pulse(tick_1hz));

   clk12_sexa_stage u_sec (
      .clk(clk), .rst(rst), .ent(tick_1hz),
      .ones(sec_ones), .tens(sec_tens), .rco(sec_rco));

   clk12_sexa_stage u_min (
      .clk(clk), .rst(rst), .ent(sec_rco),
      .ones(min_ones), .tens(min_tens), .rco(min_rco));

   clk12_hour_stage u_hr (
      .clk(clk), .rst(rst), .ent(min_rco),
      .ones(hr_ones), .tens(hr_tens));

   // R1: reset gives 12:00:00
   a_r1_reset_face: assert property (@(posedge clk)
      rst |=> (hr_tens == 4'd1 && hr_ones == 4'd2 && min_tens == 4'd0
               && min_ones == 4'd0 && sec_tens == 4'd0 && sec_ones == 4'd0));
   // R4: minutes move only as the seconds leave 59
   a_r4_minute_from_seconds: assert property (@(posedge clk) disable iff (rst)
      !$stable(min_ones) |-> ($past(sec_tens) == 4'd5 && $past(sec_ones) == 4'd9
                              && sec_tens == 4'd0 && sec_ones == 4'd0));
   // R8: no second pulse, no change anywhere on the face
   a_r8_face_hold: assert property (@(posedge clk) disable iff (rst)
      !tick_1hz |=> ($stable(sec_ones) && $stable(min_ones) && $stable(hr_ones)
                     && $stable(hr_tens)));
endmodule

// File: tb/sim_bcd_clock12.sv
module sim_bcd_clock12;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 2;
   localparam int DAY        = 12 * 3600;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ref_tick = 1'b0;
   logic       tick_1hz;
   logic [3:0] sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens;

   int checks = 0;
   int errors = 0;
   bit done   = 0;
   int pc     = 0;   // reference prescaler count
   int tod    = 0;   // seconds since 12:00:00

   always #(CLK_PERIOD / 2) clk = ~clk;

   bcd_clock12 #(.PRESCALE_DIV(DIV)) u0 (
      .clk(clk), .rst(rst), .ref_tick(ref_tick), .tick_1hz(tick_1hz),
      .sec_ones(sec_ones), .sec_tens(sec_tens), .min_ones(min_ones),
      .min_tens(min_tens), .hr_ones(hr_ones), .hr_tens(hr_tens));

   function automatic logic [23:0] face_of(input int t);
      int h, m, s;
      h = t / 3600;
      if (h == 0) h = 12;
      m = (t / 60) % 60;
      s = t % 60;
      return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
   endfunction

   function automatic string tag_of(input int prev, input bit moved);
      if (!moved)                return "R8";
      if (prev == DAY - 1)       return "R5";
      if (prev == 3599)          return "R6";
      if (prev == 9 * 3600 + 3599) return "R7";
      if (prev % 60 == 59)       return "R4";
      return "R3";
   endfunction

   task automatic check_face(input string tag);
      logic [23:0] act, exp;
      act = {hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones};
      exp = face_of(tod);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s face actual %h expected %h", tag, act, exp);
      end
   endtask

   // called at a negedge: drive, check pulse, step model, check face at next negedge
   task automatic step(input logic r);
      bit exp_pulse;
      int prev;
      ref_tick = r;
      #1;
      exp_pulse = r && (pc == DIV - 1);
      checks++;
      if (tick_1hz !== exp_pulse) begin
         errors++;
         $display("FAIL R2 tick_1hz actual %b expected %b", tick_1hz, exp_pulse);
      end
      prev = tod;
      if (r) begin
         if (pc == DIV - 1) begin
            pc = 0;
            tod = (tod + 1) % DAY;
         end else pc++;
      end
      @(negedge clk);
      check_face(tag_of(prev, prev != tod));
   endtask

   task automatic do_reset(input string tag);
      rst = 1'b1;
      ref_tick = 1'b0;
      repeat (3) @(negedge clk);
      pc = 0;
      tod = 0;
      check_face(tag);
      checks++;
      if (tick_1hz !== 1'b0) begin
         errors++;
         $display("FAIL %s tick_1hz actual %b expected 0", tag, tick_1hz);
      end
      rst = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd2718));
      @(negedge clk);
      do_reset("R1");
      // random reference with gaps
      for (int i = 0; i < 3000; i++) step(1'(($urandom % 3) != 0));
      // full face cycle with the reference held high
      for (int i = 0; i < DAY * DIV + 200; i++) step(1'b1);
      // mid-count reset after some random activity
      for (int i = 0; i < 257; i++) step(1'(($urandom % 2) != 0));
      do_reset("R9");
      step(1'b1);
      step(1'b1);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired before the run ended");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule